// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block sits behind a single-precision binary arithmetic unit once that unit has found at least one NaN among its two inputs. It decodes both operands itself, decides which one's NaN travels to the result, and converts a signaling NaN it passes on into a quiet one. When the default-NaN switch is on, it returns the canonical NaN in place of any input payload. It also reports an invalid-operation flag whenever a signaling NaN was among the inputs.

Every policy is chosen per operation at run time through mode inputs:
- which polarity of the top fraction bit marks a signaling NaN;
- whether signaling NaNs exist at all;
- whether default-NaN substitution applies;
- which of four selection rules picks the operand.

Both outputs are registered, so a result appears one clock after its operands. Detecting that a NaN is present, and producing any non-NaN result, are left to the surrounding datapath.

Top module: `nan_pick_unit`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its 23-bit fraction is nonzero. With `sig_top_set`=0 a NaN is signaling when fraction bit 22 is 0. With `sig_top_set`=1 it is signaling when bit 22 is 1. `invalid_q` is 1 one cycle after either operand is signaling, including in default-NaN mode.
- R2: With `no_sig_mode`=1 every NaN counts as quiet. `invalid_q` stays 0, and the chosen operand is passed through unchanged.
- R3: With `dflt_mode`=1 the result is the default NaN. This is 0x7FC00000 when `sig_top_set`=0 and 0x7FBFFFFF when `sig_top_set`=1, whatever operand the rule would have picked.
- R4: With `rule_sel`=0 (first-wins), the result comes from a when a is any NaN, otherwise from b.
- R5: With `rule_sel`=1 (second-wins), the result comes from b when b is any NaN, otherwise from a.
- R6: With `rule_sel`=2 (magnitude rule), a signaling NaN paired with a quiet NaN yields the quiet one. A NaN paired with a non-NaN yields the NaN.
- R7: Under `rule_sel`=2, when both operands are the same kind of NaN, the one with the larger value ignoring the sign bit wins. On an exact tie, a wins only when a's raw 32-bit value is below b's, so the positive operand is preferred.
- R8: With `rule_sel`=3 (signaling-first), the priority is: a when it is signaling, then b when it is signaling, then a when it is quiet, otherwise b.
- R9: With `sig_top_set`=0, a chosen signaling NaN is quieted by setting fraction bit 22. All other bits are kept.
- R10: With `sig_top_set`=1, a chosen signaling NaN is quieted by clearing fraction bit 22 and setting bit 21. All other bits are kept.
- R11: The synchronous active-high reset clears `nan_q` and `invalid_q` to 0. Otherwise, outputs follow the inputs with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| sig_top_set | input | 1 | 1: a set top fraction bit marks a signaling NaN |
| no_sig_mode | input | 1 | 1: all NaNs are treated as quiet |
| dflt_mode | input | 1 | 1: return the default NaN |
| rule_sel | input | 2 | Selection rule: 0 first-wins, 1 second-wins, 2 magnitude, 3 signaling-first |
| nan_q | output | 32 | Registered NaN result |
| invalid_q | output | 1 | Registered invalid-operation flag |

## Verification
On every cycle, the assertions check the following:
- in no-signaling mode, invalid is never raised;
- default-NaN mode always yields the canonical pattern;
- whenever a NaN was present, the result is a NaN that is quiet under the active polarity;
- under first-wins, a quiet first-operand NaN is passed through bit for bit.

Some behaviour can only be shown by the bench's scenarios against its reference function. This covers the orderings of the magnitude and signaling-first rules, the sign-based tie-break, the exact silenced payloads under both polarities, and the invalid flag in default-NaN mode.

// File: rtl/nanp_pkg.sv
package nanp_pkg;
  typedef enum logic [1:0] {
    RULE_FIRST  = 2'd0,
    RULE_SECOND = 2'd1,
    RULE_MAG    = 2'd2,
    RULE_SIGPRI = 2'd3
  } rule_e;

  typedef struct packed {
    logic is_nan;
    logic is_sig;
  } nclass_t;
endpackage

// File: rtl/nanp_classify.sv
module nanp_classify
  import nanp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W-1:0] mag,
  input  logic                    sig_top_set,
  input  logic                    no_sig_mode,
  output nclass_t                 cls
);
  localparam int QBIT = FRAC_W - 1;

  logic exp_full;
  logic frac_nz;

  always_comb begin
    exp_full   = &mag[EXP_W+FRAC_W-1:FRAC_W];
    frac_nz    = |mag[FRAC_W-1:0];
    cls.is_nan = exp_full && frac_nz;
    cls.is_sig = cls.is_nan && !no_sig_mode && (mag[QBIT] == sig_top_set);
  end
endmodule

// File: rtl/nanp_select.sv
module nanp_select
  import nanp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  input  nclass_t               ca,
  input  nclass_t               cb,
  input  rule_e                 rule,
  output logic                  pick_b
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic a_larger;

  // Sign-stripped magnitude compare; on a tie the positive operand counts as larger.
  always_comb begin
    if (a[W-2:0] < b[W-2:0])      a_larger = 1'b0;
    else if (b[W-2:0] < a[W-2:0]) a_larger = 1'b1;
    else                          a_larger = (a < b);
  end

  always_comb begin
    pick_b = 1'b0;
    case (rule)
      RULE_FIRST:  pick_b = !ca.is_nan;
      RULE_SECOND: pick_b = cb.is_nan;
      RULE_MAG: begin
        if (ca.is_sig && cb.is_nan && !cb.is_sig)      pick_b = 1'b1;
        else if (cb.is_sig && ca.is_nan && !ca.is_sig) pick_b = 1'b0;
        else if (ca.is_nan && cb.is_nan)               pick_b = !a_larger;
        else                                           pick_b = !ca.is_nan;
      end
      RULE_SIGPRI: begin
        if (ca.is_sig)      pick_b = 1'b0;
        else if (cb.is_sig) pick_b = 1'b1;
        else if (ca.is_nan) pick_b = 1'b0;
        else                pick_b = 1'b1;
      end
      default: pick_b = 1'b0;
    endcase
  end
endmodule

// File: rtl/nanp_quieten.sv
module nanp_quieten #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] chosen,
  input  logic                  chosen_sig,
  input  logic                  sig_top_set,
  input  logic                  dflt_mode,
  output logic [EXP_W+FRAC_W:0] result
);
  localparam int W    = 1 + EXP_W + FRAC_W;
  localparam int QBIT = FRAC_W - 1;

  logic [FRAC_W-1:0] dflt_frac;

  always_comb begin
    dflt_frac = sig_top_set ? {1'b0, {(FRAC_W-1){1'b1}}}
                            : {1'b1, {(FRAC_W-1){1'b0}}};
    result = chosen;
    if (dflt_mode) begin
      result = {1'b0, {EXP_W{1'b1}}, dflt_frac};
    end else if (chosen_sig) begin
      if (sig_top_set) begin
        result[QBIT]   = 1'b0;
        result[QBIT-1] = 1'b1;
      end else begin
        result[QBIT] = 1'b1;
      end
    end
  end

  initial begin
    assert (FRAC_W >= 2 && W > FRAC_W) else $error("fraction field too narrow");
  end
endmodule

// File: rtl/nan_pick_unit.sv
module nan_pick_unit
  import nanp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sig_top_set,
  input  logic         no_sig_mode,
  input  logic         dflt_mode,
  input  logic [1:0]   rule_sel,
  output logic [W-1:0] nan_q,
  output logic         invalid_q
);
  localparam int QBIT = FRAC_W - 1;
  localparam logic [W-1:0] DFLT_NORM = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] DFLT_INV  = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

  logic [W-1:0] ops [2];
  nclass_t      cls [2];
  logic         pick_b;
  logic [W-1:0] chosen;
  logic         chosen_sig;
  logic [W-1:0] result_d;
  logic         past_ok;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    nanp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .mag         (ops[i][W-2:0]),
      .sig_top_set (sig_top_set),
      .no_sig_mode (no_sig_mode),
      .cls         (cls[i])
    );
  end

  nanp_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
    .a      (op_a),
    .b      (op_b),
    .ca     (cls[0]),
    .cb     (cls[1]),
    .rule   (rule_e'(rule_sel)),
    .pick_b (pick_b)
  );

  assign chosen     = pick_b ? op_b : op_a;
  assign chosen_sig = pick_b ? cls[1].is_sig : cls[0].is_sig;

  nanp_quieten #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_qt (
    .chosen      (chosen),
    .chosen_sig  (chosen_sig),
    .sig_top_set (sig_top_set),
    .dflt_mode   (dflt_mode),
    .result      (result_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nan_q     <= '0;
      invalid_q <= 1'b0;
      past_ok   <= 1'b0;
    end else begin
      nan_q     <= result_d;
      invalid_q <= cls[0].is_sig || cls[1].is_sig;
      past_ok   <= 1'b1;
    end
  end

  // R2: no signaling NaNs means no invalid
  p_nosig_invalid_r2: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(no_sig_mode) |-> !invalid_q);

  // R3: default-NaN mode yields the canonical pattern
  p_default_nan_r3: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(dflt_mode) |-> nan_q == ($past(sig_top_set) ? DFLT_INV : DFLT_NORM));

  // R4: quiet NaN in a passes through untouched under first-wins
  p_first_pass_r4: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(rule_sel == 2'd0 && !dflt_mode && cls[0].is_nan && !cls[0].is_sig)
    |-> nan_q == $past(op_a));

  // R9: normal polarity result is a quiet NaN
  p_quiet_norm_r9: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(!sig_top_set && !no_sig_mode && (cls[0].is_nan || cls[1].is_nan))
    |-> nan_q[QBIT] && (&nan_q[W-2:FRAC_W]));

  // R10: inverted polarity result is a quiet NaN
  p_quiet_inv_r10: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(sig_top_set && !no_sig_mode && (cls[0].is_nan || cls[1].is_nan))
    |-> !nan_q[QBIT] && (|nan_q[FRAC_W-1:0]) && (&nan_q[W-2:FRAC_W]));
endmodule

// File: tb/nan_pick_unit_tb.sv
module nan_pick_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0, op_b = '0;
  logic        sig_top_set = 1'b0, no_sig_mode = 1'b0, dflt_mode = 1'b0;
  logic [1:0]  rule_sel = '0;
  logic [31:0] nan_q;
  logic        invalid_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nan_pick_unit u_dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .sig_top_set(sig_top_set), .no_sig_mode(no_sig_mode), .dflt_mode(dflt_mode),
    .rule_sel(rule_sel), .nan_q(nan_q), .invalid_q(invalid_q)
  );

  function automatic bit m_nan(logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  function automatic bit m_sig(logic [31:0] v, bit inv, bit nos);
    if (!m_nan(v) || nos) return 1'b0;
    return inv ? v[22] : !v[22];
  endfunction

  // returns {invalid, result}
  function automatic logic [32:0] model(logic [31:0] a, logic [31:0] b,
                                        bit inv, bit nos, bit dfl, logic [1:0] r);
    bit an = m_nan(a), bn = m_nan(b);
    bit as = m_sig(a, inv, nos), bs = m_sig(b, inv, nos);
    bit use_b, a_big;
    logic [31:0] res;
    if (a[30:0] > b[30:0])      a_big = 1'b1;
    else if (a[30:0] < b[30:0]) a_big = 1'b0;
    else                        a_big = (a < b);
    case (r)
      2'd0: use_b = !an;
      2'd1: use_b = bn;
      2'd2: begin
        if (an && bn && (as != bs)) use_b = as;
        else if (an && bn)          use_b = !a_big;
        else                        use_b = !an;
      end
      default: use_b = as ? 1'b0 : bs ? 1'b1 : an ? 1'b0 : 1'b1;
    endcase
    res = use_b ? b : a;
    if (dfl) res = inv ? 32'h7FBFFFFF : 32'h7FC00000;
    else if (use_b ? bs : as) begin
      if (inv) begin res[22] = 1'b0; res[21] = 1'b1; end
      else res[22] = 1'b1;
    end
    return {as | bs, res};
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input bit inv,
                       input bit nos, input bit dfl, input logic [1:0] r, input string tag);
    logic [32:0] exp_v;
    @(negedge clk);
    op_a = a; op_b = b; sig_top_set = inv; no_sig_mode = nos; dflt_mode = dfl; rule_sel = r;
    exp_v = model(a, b, inv, nos, dfl, r);
    @(negedge clk);
    n_checks++;
    if ({invalid_q, nan_q} !== exp_v) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h inv=%0b nos=%0b dfl=%0b rule=%0d got inv=%0b res=%h exp inv=%0b res=%h",
               tag, a, b, inv, nos, dfl, r, invalid_q, nan_q, exp_v[32], exp_v[31:0]);
    end
  endtask

  function automatic logic [31:0] rand_op(int kind);
    logic [31:0] v = $urandom;
    case (kind)
      0: v[30:23] = 8'($urandom % 255);
      1: begin v[30:23] = 8'hFF; v[22] = 1'b1; end
      2: begin v[30:23] = 8'hFF; v[22] = 1'b0; if (v[21:0] == 0) v[0] = 1'b1; end
      default: v = ($urandom % 2) ? 32'h7FC00001 : 32'hFF800003;
    endcase
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    n_checks++;
    if (nan_q !== 32'h0 || invalid_q !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 reset: got res=%h inv=%0b exp res=00000000 inv=0", nan_q, invalid_q);
    end
    rst = 1'b0;

    apply(32'h3F800000, 32'hFFC00002, 0, 0, 0, 2'd0, "R4 non-NaN a");
    apply(32'h7F800005, 32'hFFC00002, 0, 0, 0, 2'd0, "R4 R9 silence a");
    apply(32'h7FC00001, 32'h3F800000, 0, 0, 0, 2'd1, "R5 b not NaN");
    apply(32'h7FC00001, 32'h7FA00000, 0, 0, 0, 2'd1, "R5 R1 silence b");
    apply(32'h7F800005, 32'hFFC00002, 0, 0, 0, 2'd2, "R6 sig vs quiet");
    apply(32'hFFC00002, 32'h7F800005, 0, 0, 0, 2'd2, "R6 quiet vs sig");
    apply(32'h7FC00001, 32'h7FC00002, 0, 0, 0, 2'd2, "R7 larger b");
    apply(32'hFFC00001, 32'h7FC00001, 0, 0, 0, 2'd2, "R7 tie b positive");
    apply(32'h7FC00001, 32'hFFC00001, 0, 0, 0, 2'd2, "R7 tie a positive");
    apply(32'h7FC00001, 32'h7FA00000, 0, 0, 0, 2'd3, "R8 sig b first");
    apply(32'h7F800005, 32'hFFC00002, 0, 0, 1, 2'd0, "R3 R1 default normal");
    apply(32'h7FC00003, 32'h3F800000, 1, 0, 1, 2'd0, "R3 default inverted");
    apply(32'h7FC00003, 32'h3F800000, 1, 0, 0, 2'd0, "R10 inverted silence");
    apply(32'h7F800005, 32'h7FA00000, 0, 1, 0, 2'd0, "R2 no signaling");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a = rand_op(int'($urandom % 4));
      logic [31:0] b = rand_op(int'($urandom % 4));
      logic [1:0]  r = 2'($urandom);
      if (!m_nan(a) && !m_nan(b)) a = rand_op(2);
      case (r)
        2'd0: apply(a, b, 1'($urandom), 1'($urandom % 5 == 0), 1'($urandom % 6 == 0), r, "R4 random");
        2'd1: apply(a, b, 1'($urandom), 1'($urandom % 5 == 0), 1'($urandom % 6 == 0), r, "R5 random");
        2'd2: apply(a, b, 1'($urandom), 1'($urandom % 5 == 0), 1'($urandom % 6 == 0), r, "R6 R7 random");
        default: apply(a, b, 1'($urandom), 1'($urandom % 5 == 0), 1'($urandom % 6 == 0), r, "R8 random");
      endcase
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule